// File: doc/BRIEF.md
# Crosstalk-Avoiding Bus Segment Receiver

This block sits at the processor end of a wide instruction fetch bus. The bus carries four 32-bit lanes per cycle, and each lane is followed by a small marker field. The sender may replace any lane with an all-zero filler segment so that neighbouring wires never switch against each other. Each cycle the receiver reads the markers to find out which lanes hold real instruction data. It packs those lanes in order behind any segments left over from earlier cycles. It hands every complete 128-bit fetch word to the prefetch queue with a one-cycle push strobe.

Words may arrive spread over several cycles, and a cycle may carry no data at all. At most three segments stay in a staging register between cycles. When the queue reports full and the current cycle would complete a word, the receiver raises a stall and consumes nothing. The sender must then hold the same bus contents until the stall drops.

Top module: `ctk_seg_receiver`

## Requirements
- R1: Lane 1 data is on bus bits [134:103], lane 2 on [100:69], lane 3 on [66:35] and lane 4 on [32:1]. Within a pushed word, the first segment occupies bits [127:96] and the fourth occupies bits [31:0].
- R2: Lanes 1 to 3 carry data only when their two-bit marker directly below the lane ([102:101], [68:67], [34:33]) equals 2'b10. Any other marker value (00, 01, 11) makes the lane a filler. Lane 4 carries data when bit [0] is 1.
- R3: A filler lane never contributes to a pushed word, whatever its data bits hold. A cycle with no data lane pushes nothing and leaves the staging register unchanged.
- R4: Data lanes of one cycle are appended in lane order 1, 2, 3, 4, after the segments already staged.
- R5: When the staged count plus this cycle's data lanes reaches four or more and the queue is not full, push is high in that same cycle and push_word holds the four oldest segments.
- R6: Data segments beyond the four that complete a word stay staged and begin the next word.
- R7: When a word would complete while queue_full is high, stall is high and push is low. Staged contents are unchanged, so the held bus contents are accepted once queue_full drops.
- R8: When queue_full is high but no word completes, stall stays low and the cycle's data segments are staged.
- R9: Reset clears the staging register, so the first four segments after reset form a word by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 135 | Received bus: four lanes with markers |
| queue_full | input | 1 | Prefetch queue cannot take a word |
| push | output | 1 | push_word is written to the queue this cycle |
| push_word | output | 128 | Reassembled fetch word |
| stall | output | 1 | Sender must hold the bus; nothing consumed |

## Verification
A word completion and a full queue can fall in the same cycle. The receiver must then choose between pushing and stalling while leaving its staging register untouched. The bench sweeps every pair of consecutive lane masks, with queue_full toggled by an arithmetic rule, so the stall arises from every staged count and every mask. On each stall it holds the bus for a second cycle with queue_full low. It then judges stall, push and the full word against a segment-list model, and this also shows that the retried lanes were neither lost nor taken twice.

// File: rtl/ctk_pkg.sv
package ctk_pkg;
  // total wires: each lane plus a 2-bit marker, the last marker is 1 bit
  function automatic int bus_width(int seg_w, int nseg);
    return nseg * seg_w + 2 * nseg - 1;
  endfunction

  // top bit of lane k (k = 0 is lane 1)
  function automatic int lane_msb(int k, int seg_w, int nseg);
    return bus_width(seg_w, nseg) - 1 - k * (seg_w + 2);
  endfunction
endpackage

// File: rtl/ctk_lane_decode.sv
module ctk_lane_decode
  import ctk_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int NSEG  = 4,
  localparam int BUS_W = bus_width(SEG_W, NSEG)
) (
  input  logic [BUS_W-1:0]            bus_in,
  output logic [NSEG-1:0][SEG_W-1:0]  seg_data,
  output logic [NSEG-1:0]             seg_vld
);
  for (genvar k = 0; k < NSEG; k++) begin : g_lane
    localparam int MSB = lane_msb(k, SEG_W, NSEG);
    assign seg_data[k] = bus_in[MSB -: SEG_W];
    if (k < NSEG - 1) begin : g_pair
      assign seg_vld[k] = (bus_in[MSB-SEG_W -: 2] == 2'b10);
    end else begin : g_last
      assign seg_vld[k] = bus_in[MSB-SEG_W];
    end
  end
endmodule

// File: rtl/ctk_packer.sv
module ctk_packer #(
  parameter int SEG_W = 32,
  parameter int NSEG  = 4,
  localparam int CNT_W = $clog2(NSEG),
  localparam int TOT_W = $clog2(2 * NSEG)
) (
  input  logic [NSEG-2:0][SEG_W-1:0]   stage,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NSEG-1:0][SEG_W-1:0]   seg_data,
  input  logic [NSEG-1:0]              seg_vld,
  output logic [2*NSEG-1:0][SEG_W-1:0] slots,
  output logic [TOT_W-1:0]             total
);
  logic [TOT_W-1:0] acc;

  always_comb begin
    slots = '0;
    for (int j = 0; j < NSEG - 1; j++) begin
      if (CNT_W'(j) < cnt) slots[j] = stage[j];
    end
    acc = TOT_W'(cnt);
    for (int k = 0; k < NSEG; k++) begin
      if (seg_vld[k]) begin
        slots[acc] = seg_data[k];
        acc = acc + TOT_W'(1);
      end
    end
    total = acc;
  end
endmodule

// File: rtl/ctk_seg_receiver.sv
module ctk_seg_receiver
  import ctk_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int NSEG  = 4,
  localparam int BUS_W  = bus_width(SEG_W, NSEG),
  localparam int WORD_W = SEG_W * NSEG,
  localparam int CNT_W  = $clog2(NSEG),
  localparam int TOT_W  = $clog2(2 * NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              queue_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              stall
);
  localparam logic [TOT_W-1:0] NSEG_T = TOT_W'(NSEG);

  logic [NSEG-1:0][SEG_W-1:0]   seg_data;
  logic [NSEG-1:0]              seg_vld;
  logic [2*NSEG-1:0][SEG_W-1:0] slots;
  logic [TOT_W-1:0]             total;
  logic [NSEG-2:0][SEG_W-1:0]   stage_q, stage_nxt;
  logic [CNT_W-1:0]             cnt_q, cnt_nxt;
  logic                         complete, stage_en;

  ctk_lane_decode #(.SEG_W(SEG_W), .NSEG(NSEG)) u_decode (
    .bus_in   (bus_in),
    .seg_data (seg_data),
    .seg_vld  (seg_vld)
  );

  ctk_packer #(.SEG_W(SEG_W), .NSEG(NSEG)) u_packer (
    .stage    (stage_q),
    .cnt      (cnt_q),
    .seg_data (seg_data),
    .seg_vld  (seg_vld),
    .slots    (slots),
    .total    (total)
  );

  assign complete = (total >= NSEG_T);
  assign stall    = complete & queue_full;
  assign push     = complete & ~queue_full;
  assign stage_en = ~stall;

  for (genvar j = 0; j < NSEG; j++) begin : g_word
    assign push_word[WORD_W-1-j*SEG_W -: SEG_W] = slots[j];
  end

  always_comb begin
    for (int j = 0; j < NSEG - 1; j++) begin
      stage_nxt[j] = complete ? slots[j+NSEG] : slots[j];
    end
    cnt_nxt = complete ? CNT_W'(total - NSEG_T) : CNT_W'(total);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else if (stage_en) begin
      cnt_q   <= cnt_nxt;
      stage_q <= stage_nxt;
    end
  end
endmodule

// File: rtl/ctk_seg_receiver_chk.sv
module ctk_seg_receiver_chk
  import ctk_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int NSEG  = 4,
  localparam int BUS_W = bus_width(SEG_W, NSEG),
  localparam int CNT_W = $clog2(NSEG)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [BUS_W-1:0]               bus_in,
  input logic                           queue_full,
  input logic                           push,
  input logic                           stall,
  input logic [CNT_W-1:0]               cnt,
  input logic [NSEG-2:0][SEG_W-1:0]     stage
);
  logic any_data;
  always_comb begin
    any_data = bus_in[0];
    for (int k = 0; k < NSEG - 1; k++) begin
      if (bus_in[lane_msb(k, SEG_W, NSEG) - SEG_W -: 2] == 2'b10) any_data = 1'b1;
    end
  end

  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |-> !push);
  a_r7_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> queue_full);
  a_r7_hold_stage: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(cnt) && $stable(stage)));
  a_r3_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !any_data |-> (!push && !stall));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_data |=> $stable(cnt));
endmodule

bind ctk_seg_receiver ctk_seg_receiver_chk #(.SEG_W(SEG_W), .NSEG(NSEG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_in     (bus_in),
  .queue_full (queue_full),
  .push       (push),
  .stall      (stall),
  .cnt        (cnt_q),
  .stage      (stage_q)
);

// File: tb/test_ctk_seg_receiver.sv
`timescale 1ns/100ps
module test_ctk_seg_receiver;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [134:0] bus_in;
  logic         queue_full;
  logic         push;
  logic [127:0] push_word;
  logic         stall;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] pend [0:7];
  int pend_n = 0;
  int unsigned seq = 1;

  always #2.5 clk = ~clk;

  ctk_seg_receiver i_ctk_seg_receiver (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .queue_full(queue_full),
    .push(push), .push_word(push_word), .stall(stall));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lane k (0 = lane 1) at [134-34k -: 32]; markers at [102-34k -: 2], lane 4 marker bit 0
  function automatic logic [134:0] make_bus(input logic [3:0] mask, input logic junk,
                                            input logic [31:0] v [4]);
    logic [134:0] b = '0;
    for (int k = 0; k < 4; k++) begin
      if (mask[k]) begin
        b[134-34*k -: 32] = v[k];
        if (k < 3) b[102-34*k -: 2] = 2'b10; else b[0] = 1'b1;
      end else if (junk) begin
        b[134-34*k -: 32] = 32'hDEAD_0000 | k;
        if (k < 3) b[102-34*k -: 2] = (k[0] ? 2'b11 : 2'b01);
      end
    end
    return b;
  endfunction

  // called just after a falling edge; returns just after the next falling edge
  task automatic drive_cycle(input logic [3:0] mask, input logic full, input logic junk);
    logic [31:0] v [4];
    logic [31:0] sl [0:7];
    int s = seq;
    int tot;
    bit exp_push, exp_stall;
    logic [127:0] exp_word;
    logic f = full;
    for (int k = 0; k < 4; k++) begin
      v[k] = mask[k] ? (32'h5A00_0000 + s) : 32'h0;
      if (mask[k]) s++;
    end
    forever begin
      bus_in = make_bus(mask, junk, v);
      queue_full = f;
      #1;
      tot = pend_n;
      for (int j = 0; j < pend_n; j++) sl[j] = pend[j];
      for (int k = 0; k < 4; k++) if (mask[k]) begin sl[tot] = v[k]; tot++; end
      exp_push  = (tot >= 4) && !f;
      exp_stall = (tot >= 4) && f;
      exp_word  = {sl[0], sl[1], sl[2], sl[3]};
      chk(stall === exp_stall, (f && !exp_stall) ? "R8 stall" : "R7 stall", 128'(stall), 128'(exp_stall));
      chk(push === exp_push, f ? "R7 push" : "R5 push", 128'(push), 128'(exp_push));
      if (exp_push)
        chk(push_word === exp_word, junk ? "R2/R3 word" : "R1 R4 R6 word", push_word, exp_word);
      @(posedge clk);
      if (!exp_stall) begin
        if (tot >= 4) begin
          for (int j = 4; j < tot; j++) sl[j-4] = sl[j];
          tot -= 4;
        end
        for (int j = 0; j < tot; j++) pend[j] = sl[j];
        pend_n = tot;
        seq = s;
        @(negedge clk);
        break;
      end
      @(negedge clk);
      f = 1'b0;   // retry the held bus once the queue has room
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bus_in = '0;
    queue_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(push === 1'b0, "R9 reset push", 128'(push), 128'(0));
    chk(stall === 1'b0, "R9 reset stall", 128'(stall), 128'(0));
    @(negedge clk);

    // R9: partial word then reset; new word must be fresh
    drive_cycle(4'b0011, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pend_n = 0;
    drive_cycle(4'b1111, 1'b0, 1'b0);

    // R3: idle cycles with junk markers on filler lanes
    drive_cycle(4'b0000, 1'b1, 1'b1);
    drive_cycle(4'b0000, 1'b0, 1'b1);

    // sweep every pair of masks, toggling full and junk arithmetically
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        drive_cycle(4'(a), 1'((a + b) % 3 == 0), 1'(b[0]));
        drive_cycle(4'(b), 1'((a ^ b) & 1), 1'(a[1]));
      end
    end
    finish_run();
  end
endmodule